// File: doc/BRIEF.md
# Downstream Bus Connection Controller

This block manages the four pass switches of a two-wire bus multiplexer. Each switch joins one downstream bus segment to the shared upstream bus. A host sets connection requests through a small parallel register port. The block grants a request only when the target segment is idle, meaning both of its lines are high. An override bit can be set to connect regardless of the segment's level. The granted state is what reads back, so a refused request shows up as a zero.

The block also holds configuration for the rest of the device: a direction and an output-type control for each of two general-purpose pins, and an enable for answering a fixed broadcast address. A stuck-low guard watches the upstream bus. If the data or clock line stays low past a selectable time, every switch is opened and a sticky flag is raised for the host to clear.

Top module: `busmux_conn_ctrl`

## Requirements
- R1: After reset all switches are open. Both pin directions and both output types are 0, the override is 0, the broadcast enable is 1, the timeout selector is 00 and the timeout flag is 0. Register 0 reads 0x20 and register 2 reads 0x00.
- R2: Writing register 1 with bit i = 1 closes switch i (sw_en[i] = 1) at the next clock edge when the grant rule allows it. Writing bit i = 0 opens it. Bits [3:0] of register 1 read back the switch states.
- R3: Bit 4+i of register 1 reads the idle level of bus i: 1 only when dn_sda[i] and dn_scl[i] are both high, and 0 if either is low. It is seen through a two-flop synchronizer, and writes to bits [7:4] have no effect.
- R4: With the override (register 0 bit 4) at 0, a request for an open bus whose idle level is 0 is refused. The switch stays open and the bit reads 0.
- R5: With the override at 1, requested switches close whatever the downstream level.
- R6: A switch that is already closed stays closed when rewritten with 1, whatever its bus's idle level.
- R7: Register 0 bits [1:0] drive gpio_dir, bits [3:2] drive gpio_pp and bit 5 drives mass_wr_en. All three follow writes at the next edge.
- R8: Register 0 bits [7:6] select the timeout: 01 is 30 ms, 10 is 15 ms and 11 is 7.5 ms, with CYC_PER_MS clock cycles per ms. When up_sda or up_scl (after synchronization) stays low for the limit, all switches open and tmo_flag sets.
- R9: The stuck-low count restarts whenever both upstream lines are high, and selector 00 never times out.
- R10: tmo_flag (register 2 bit 0) stays set until register 2 is written with bit 0 = 1. A write with bit 0 = 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 config, 1 switches, 2 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| dn_sda | input | NBUS | Downstream data line levels |
| dn_scl | input | NBUS | Downstream clock line levels |
| up_sda | input | 1 | Upstream data line level |
| up_scl | input | 1 | Upstream clock line level |
| sw_en | output | NBUS | Switch enables, 1 = bus joined |
| gpio_dir | output | NGPIO | Pin direction, 1 = input |
| gpio_pp | output | NGPIO | Pin output type, 1 = push-pull |
| mass_wr_en | output | 1 | Broadcast address enable |
| tmo_flag | output | 1 | Sticky stuck-low timeout flag |

## Verification
On every cycle the assertions check the following. A switch rises only after a write that requested it while the override or the synchronized idle level allowed it. The switch vector changes only through a switch write or a timeout. An expiry opens every switch and sets the flag. A disabled selector never expires, and the flag neither appears nor vanishes without its cause. The exact timeout lengths for each selector code, the restart of the count when the upstream lines go high, the synchronizer delay on the idle bits and the read-back of refused requests can only be shown by the bench's scenarios.

// File: rtl/busmux_pkg.sv
package busmux_pkg;
  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_SW   = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  // Limit in clock cycles of continuous upstream low for a selector code.
  function automatic int unsigned tmo_limit(input logic [1:0] sel, input int unsigned cpms);
    case (sel)
      2'b01:   return 30 * cpms;
      2'b10:   return 15 * cpms;
      2'b11:   return (15 * cpms) / 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/bm_sync2.sv
module bm_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= rst_val[i];
        s2 <= rst_val[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/bm_sw_decide.sv
module bm_sw_decide #(
  parameter int NBUS = 4
) (
  input  logic [NBUS-1:0] req,
  input  logic [NBUS-1:0] cur,
  input  logic [NBUS-1:0] idle,
  input  logic            any_level,
  output logic [NBUS-1:0] nxt,
  output logic [NBUS-1:0] refused
);
  for (genvar i = 0; i < NBUS; i++) begin : g_bus
    // A closed bus keeps its grant; an open bus needs idle or the override.
    assign nxt[i]     = req[i] & (any_level | idle[i] | cur[i]);
    assign refused[i] = req[i] & ~nxt[i];
  end
endmodule

// File: rtl/bm_stuck_timer.sv
module bm_stuck_timer
  import busmux_pkg::*;
#(
  parameter int CYC_PER_MS = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_low,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int CNT_W = $clog2(30 * CYC_PER_MS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic             armed;
  int unsigned      lim;

  assign lim    = tmo_limit(sel, CYC_PER_MS);
  assign armed  = (sel != 2'b00) && line_low && !fired_q;
  assign expire = armed && (32'(cnt_q) >= lim - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (!line_low || sel == 2'b00) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (expire) begin
      cnt_q   <= '0;
      fired_q <= 1'b1;
    end else if (armed) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/busmux_conn_ctrl.sv
module busmux_conn_ctrl
  import busmux_pkg::*;
#(
  parameter int NBUS       = 4,
  parameter int NGPIO      = 2,
  parameter int CYC_PER_MS = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [NBUS-1:0]  dn_sda,
  input  logic [NBUS-1:0]  dn_scl,
  input  logic             up_sda,
  input  logic             up_scl,
  output logic [NBUS-1:0]  sw_en,
  output logic [NGPIO-1:0] gpio_dir,
  output logic [NGPIO-1:0] gpio_pp,
  output logic             mass_wr_en,
  output logic             tmo_flag
);
  localparam int SW_W = NBUS + 1;

  logic [NGPIO-1:0] gdir_q, gpp_q;
  logic             any_q, mass_q, flag_q;
  logic [1:0]       tsel_q;
  logic [NBUS-1:0]  sw_q, sw_nxt, sw_refused, idle_s;
  logic [SW_W-1:0]  sync_in, sync_out;
  logic             up_low_s, tmo_expire;
  logic             wr_cfg, wr_sw, wr_stat;

  assign sync_in = {~(up_sda & up_scl), dn_sda & dn_scl};
  bm_sync2 #(.W(SW_W)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .rst_val('0), .q(sync_out)
  );
  assign idle_s   = sync_out[NBUS-1:0];
  assign up_low_s = sync_out[NBUS];

  bm_sw_decide #(.NBUS(NBUS)) dec_i (
    .req(wdata[NBUS-1:0]), .cur(sw_q), .idle(idle_s), .any_level(any_q),
    .nxt(sw_nxt), .refused(sw_refused)
  );

  bm_stuck_timer #(.CYC_PER_MS(CYC_PER_MS)) tmr_i (
    .clk(clk), .rst_n(rst_n), .line_low(up_low_s), .sel(tsel_q), .expire(tmo_expire)
  );

  assign wr_cfg  = wr_en && addr == A_CFG;
  assign wr_sw   = wr_en && addr == A_SW;
  assign wr_stat = wr_en && addr == A_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gdir_q <= '0;
      gpp_q  <= '0;
      any_q  <= 1'b0;
      mass_q <= 1'b1;
      tsel_q <= 2'b00;
    end else if (wr_cfg) begin
      gdir_q <= wdata[1:0];
      gpp_q  <= wdata[3:2];
      any_q  <= wdata[4];
      mass_q <= wdata[5];
      tsel_q <= wdata[7:6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sw_q <= '0;
    else if (tmo_expire) sw_q <= '0;
    else if (wr_sw)      sw_q <= sw_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag_q <= 1'b0;
    else if (tmo_expire)           flag_q <= 1'b1;
    else if (wr_stat && wdata[0])  flag_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_CFG:   rdata = {tsel_q, mass_q, any_q, gpp_q, gdir_q};
      A_SW:    rdata = {idle_s, sw_q};
      A_STAT:  rdata = {7'd0, flag_q};
      default: rdata = 8'd0;
    endcase
  end

  assign sw_en      = sw_q;
  assign gpio_dir   = gdir_q;
  assign gpio_pp    = gpp_q;
  assign mass_wr_en = mass_q;
  assign tmo_flag   = flag_q;
endmodule

// File: rtl/busmux_conn_ctrl_chk.sv
module busmux_conn_ctrl_chk #(
  parameter int NBUS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [7:0]      wdata,
  input logic [NBUS-1:0] sw_en,
  input logic [NBUS-1:0] idle_s,
  input logic            any_q,
  input logic [1:0]      tsel,
  input logic            expire,
  input logic            tmo_flag
);
  for (genvar i = 0; i < NBUS; i++) begin : g_bus
    // R4, R5: a switch rises only after a permitted request
    p_close_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_en[i]) |-> $past(wr_en && addr == 2'd1 && wdata[i] && (any_q || idle_s[i])));
  end

  p_sw_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_en) |-> ($past(wr_en && addr == 2'd1) || $past(expire)));

  p_expire_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (sw_en == '0 && tmo_flag));

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tsel == 2'b00 |-> !expire);

  p_flag_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(expire));

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !(wr_en && addr == 2'd2 && wdata[0])) |=> tmo_flag);
endmodule

bind busmux_conn_ctrl busmux_conn_ctrl_chk #(.NBUS(NBUS)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .sw_en(sw_en), .idle_s(idle_s), .any_q(any_q), .tsel(tsel_q),
  .expire(tmo_expire), .tmo_flag(tmo_flag)
);

// File: tb/busmux_conn_ctrl_tb_top.sv
`timescale 1ns/1ps
module busmux_conn_ctrl_tb_top;
  localparam int CPM = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [3:0] dn_sda = 4'hF, dn_scl = 4'hF;
  logic       up_sda = 1'b1, up_scl = 1'b1;
  logic [3:0] sw_en;
  logic [1:0] gpio_dir, gpio_pp;
  logic       mass_wr_en, tmo_flag;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  busmux_conn_ctrl #(.NBUS(4), .NGPIO(2), .CYC_PER_MS(CPM)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .dn_sda(dn_sda), .dn_scl(dn_scl), .up_sda(up_sda), .up_scl(up_scl),
    .sw_en(sw_en), .gpio_dir(gpio_dir), .gpio_pp(gpio_pp),
    .mass_wr_en(mass_wr_en), .tmo_flag(tmo_flag)
  );

  // {override, sda[3:0], scl[3:0], request[3:0], expected switches[3:0]}
  localparam logic [16:0] VEC [0:7] = '{
    {1'b0, 4'hF, 4'hF, 4'b0101, 4'b0101},  // R2 idle buses close
    {1'b0, 4'hF, 4'hF, 4'b0000, 4'b0000},  // R2 writing 0 opens
    {1'b0, 4'hE, 4'hF, 4'b1111, 4'b1110},  // R4 bus 0 data low refused
    {1'b0, 4'hF, 4'h7, 4'b1111, 4'b1111},  // R6 bus 3 low but kept closed
    {1'b0, 4'h0, 4'h0, 4'b0011, 4'b0011},  // R6 closed buses survive low lines
    {1'b1, 4'h0, 4'h0, 4'b1100, 4'b1100},  // R5 override closes low buses
    {1'b0, 4'hA, 4'hF, 4'b0000, 4'b0000},  // R2 open all
    {1'b0, 4'hA, 4'hF, 4'b1111, 4'b1010}   // R4 mixed refusal
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    logic [3:0] idle;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    chk("R1 sw_en", 32'(sw_en), 32'h0);
    chk("R1 gpio_dir", 32'(gpio_dir), 32'h0);
    chk("R1 gpio_pp", 32'(gpio_pp), 32'h0);
    chk("R1 mass_wr_en", 32'(mass_wr_en), 32'h1);
    chk("R1 tmo_flag", 32'(tmo_flag), 32'h0);
    rd(2'd0, r); chk("R1 cfg read", 32'(r), 32'h20);
    rd(2'd2, r); chk("R1 status read", 32'(r), 32'h00);

    // Vector walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      wr(2'd0, VEC[v][16] ? 8'h30 : 8'h20);
      dn_sda = VEC[v][15:12];
      dn_scl = VEC[v][11:8];
      idle = VEC[v][15:12] & VEC[v][11:8];
      wait_cyc(3);
      wr(2'd1, {4'h0, VEC[v][7:4]});
      chk($sformatf("vector %0d sw_en", v), 32'(sw_en), 32'(VEC[v][3:0]));
      rd(2'd1, r);
      chk($sformatf("vector %0d R3 readback", v), 32'(r), 32'({idle, VEC[v][3:0]}));
    end

    // R3 synchronizer delay and write-ignore of idle bits
    wr(2'd1, 8'h00);
    dn_sda = 4'hF; dn_scl = 4'hF;
    addr = 2'd1;
    @(posedge clk); #1 chk("R3 one edge still old", 32'(rdata[7:4]), 32'hA);
    @(posedge clk); #1 chk("R3 two edges new", 32'(rdata[7:4]), 32'hF);
    wr(2'd1, 8'h00);
    rd(2'd1, r); chk("R3 write ignored", 32'(r), 32'hF0);

    // R7 configuration outputs
    wr(2'd0, 8'h0E);
    chk("R7 gpio_dir", 32'(gpio_dir), 32'h2);
    chk("R7 gpio_pp", 32'(gpio_pp), 32'h3);
    chk("R7 mass_wr_en", 32'(mass_wr_en), 32'h0);
    rd(2'd0, r); chk("R7 cfg read", 32'(r), 32'h0E);

    // R8 timeout, selector 11 (75 cycles) then 10 (150 cycles)
    for (int s = 0; s < 2; s++) begin
      int lim;
      lim = (s == 0) ? (15 * CPM) / 2 : 15 * CPM;
      wr(2'd0, (s == 0) ? 8'hF0 : 8'hB0);
      wr(2'd1, 8'h0F);
      up_scl = 1'b0;
      wait_cyc(lim - 4);
      chk($sformatf("R8 before limit sel%0d", s), 32'(sw_en), 32'hF);
      wait_cyc(12);
      chk($sformatf("R8 after limit sel%0d", s), 32'(sw_en), 32'h0);
      chk($sformatf("R8 flag sel%0d", s), 32'(tmo_flag), 32'h1);
      up_scl = 1'b1;
      wait_cyc(3);
      // R10 sticky flag
      wr(2'd2, 8'h00);
      chk("R10 flag kept on zero write", 32'(tmo_flag), 32'h1);
      rd(2'd2, r); chk("R10 status read", 32'(r), 32'h01);
      wr(2'd2, 8'h01);
      chk("R10 flag cleared", 32'(tmo_flag), 32'h0);
    end

    // R9 restart on high lines, selector 01 (300 cycles)
    wr(2'd0, 8'h70);
    wr(2'd1, 8'h0F);
    up_sda = 1'b0; wait_cyc(250);
    up_sda = 1'b1; wait_cyc(5);
    up_sda = 1'b0; wait_cyc(250);
    chk("R9 count restarted", 32'(sw_en), 32'hF);
    wait_cyc(60);
    chk("R8 thirty ms limit", 32'(sw_en), 32'h0);
    up_sda = 1'b1; wait_cyc(3);
    wr(2'd2, 8'h01);

    // R9 disabled selector
    wr(2'd0, 8'h30);
    wr(2'd1, 8'h0F);
    up_scl = 1'b0; wait_cyc(400);
    chk("R9 disabled keeps switches", 32'(sw_en), 32'hF);
    chk("R9 disabled no flag", 32'(tmo_flag), 32'h0);
    up_scl = 1'b1;

    finish_run();
  end
endmodule